// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is one 4-bit digit of a synchronous counter chain. Every state bit is clocked by the same edge, so no carry delay builds up from bit to bit. A mode input picks between a decade (BCD, 0 to 9) and a full binary (0 to 15) modulus. A direction input picks counting up or down. A synchronous parallel load presets the digit to any 4-bit value.

Counting needs two enable inputs, and both must be high. A terminal-count flag marks the extreme value for the current direction. A ripple-clock output is high while this stage is about to wrap and is enabled. Wiring that output into one enable of the next stage makes the next stage step on the same clock edge, which gives multidigit decimal counters or wider binary counters. The higher stage can use a different enable input than the one fed by the lower stage. Divide-by-N dividers are built outside the block by feeding the ripple clock back to the load input.

Top module: `updn_stage`

## Requirements
- R1: A high `rst` at a rising clock edge sets `cnt_q` to 0, whatever the other inputs are. Reset overrides load.
- R2: A high `load_en` (without reset) sets `cnt_q` to `load_val` at the next edge. Load overrides counting.
- R3: When neither reset nor load is active, `cnt_q` changes only if `en_a` and `en_b` are both high. Otherwise it holds.
- R4: Counting up (`dir_down`=0) adds one per edge. In binary mode (`decade_sel`=0), 15 wraps to 0. In decade mode (`decade_sel`=1), 9 wraps to 0.
- R5: Counting down (`dir_down`=1) subtracts one per edge. In binary mode 0 wraps to 15. In decade mode 0 wraps to 9.
- R6: `tc` is combinational from the present count, direction and mode. It is high when counting up at 9 (decade) or 15 (binary), and when counting down at 0. It is low otherwise, including for decade values above 9.
- R7: `rco` is high in the same cycle when `tc`, `en_a` and `en_b` are all high, and low otherwise. The counter always changes value on an edge where `rco` is high and no load occurs.
- R8: In decade mode, a count above 9 (reachable only by load) goes to 0 on the next up count and to 9 on the next down count.
- R9: Two stages on one clock, with the upper stage's `en_b` driven by the lower stage's `rco`, count as one two-digit decimal counter in both directions. Carries and borrows between the digits take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_en | input | 1 | Synchronous parallel load strobe |
| load_val | input | 4 | Value to preset |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| en_a | input | 1 | First count enable |
| en_b | input | 1 | Second count enable (cascade input) |
| decade_sel | input | 1 | 1 = decade modulus, 0 = binary modulus |
| cnt_q | output | 4 | Present count |
| tc | output | 1 | Terminal count for the present direction |
| rco | output | 1 | Ripple-clock (carry/borrow) to next stage |

## Verification
`tc` and `rco` are combinational, so they are due in the same cycle as the inputs. The bench checks them 1 ns after driving the inputs on the falling edge. `cnt_q` is registered and changes at the first rising edge after the stimulus. Each stimulus pushes the expected next count of both chained stages into a queue. A monitor pops that entry 2 ns after the rising edge and compares it with the counts. This keeps every comparison exactly one register stage behind its stimulus, including reset, load and carries between stages.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    // Decoded control for one clock edge
    typedef struct packed {
        logic clr;
        logic ld;
        logic step;
        dir_e dir;
        logic dec;
    } ctl_t;

    // Upper limit of the active modulus
    function automatic logic [7:0] mod_limit(input logic dec, input int dec_max, input int w);
        logic [7:0] full;
        full = 8'((1 << w) - 1);
        return dec ? 8'(dec_max) : full;
    endfunction

endpackage

// File: rtl/updn_ctl.sv
module updn_ctl
    import updn_pkg::*;
(
    input  logic rst,
    input  logic load_en,
    input  logic dir_down,
    input  logic en_a,
    input  logic en_b,
    input  logic decade_sel,
    output ctl_t ctl
);
    always_comb begin
        ctl.clr  = rst;
        ctl.ld   = !rst && load_en;
        ctl.step = !rst && !load_en && en_a && en_b;
        ctl.dir  = dir_down ? DIR_DN : DIR_UP;
        ctl.dec  = decade_sel;
    end
endmodule

// File: rtl/updn_next.sv
module updn_next
    import updn_pkg::*;
#(
    parameter int W       = 4,
    parameter int DEC_MAX = 9
) (
    input  ctl_t         ctl,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] nxt
);
    localparam logic [7:0] DEC_LIM = 8'(DEC_MAX);
    localparam logic [7:0] BIN_LIM = 8'((1 << W) - 1);

    logic [W-1:0] lim;
    assign lim = ctl.dec ? W'(DEC_LIM) : W'(BIN_LIM);

    logic [W-1:0] up_v;
    logic [W-1:0] dn_v;

    always_comb begin
        // Anything at or above the limit restarts at zero
        up_v = (cur >= lim) ? '0 : cur + W'(1);
        // Zero wraps to the limit; an out-of-range value is pulled to the limit
        if (cur == '0)     dn_v = lim;
        else if (cur > lim) dn_v = lim;
        else               dn_v = cur - W'(1);
    end

    always_comb begin
        if (ctl.clr)       nxt = '0;
        else if (ctl.ld)   nxt = load_val;
        else if (ctl.step) nxt = (ctl.dir == DIR_UP) ? up_v : dn_v;
        else               nxt = cur;
    end
endmodule

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
#(
    parameter int W       = 4,
    parameter int DEC_MAX = 9
) (
    input  logic [W-1:0] cur,
    input  dir_e         dir,
    input  logic         dec,
    input  logic         en_a,
    input  logic         en_b,
    output logic         tc,
    output logic         rco
);
    logic [W-1:0] top;
    assign top = W'(mod_limit(dec, DEC_MAX, W));

    always_comb begin
        tc  = (dir == DIR_UP) ? (cur == top) : (cur == '0);
        rco = tc && en_a && en_b;
    end
endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int W       = 4,
    parameter int DEC_MAX = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         dir_down,
    input  logic         en_a,
    input  logic         en_b,
    input  logic         decade_sel,
    output logic [W-1:0] cnt_q,
    output logic         tc,
    output logic         rco
);
    ctl_t         ctl;
    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_r;

    updn_ctl u_ctl (
        .rst        (rst),
        .load_en    (load_en),
        .dir_down   (dir_down),
        .en_a       (en_a),
        .en_b       (en_b),
        .decade_sel (decade_sel),
        .ctl        (ctl)
    );

    updn_next #(.W(W), .DEC_MAX(DEC_MAX)) u_next (
        .ctl      (ctl),
        .cur      (cnt_r),
        .load_val (load_val),
        .nxt      (cnt_d)
    );

    // All state bits share this one edge
    always_ff @(posedge clk) begin
        cnt_r <= cnt_d;
    end

    updn_term #(.W(W), .DEC_MAX(DEC_MAX)) u_term (
        .cur  (cnt_r),
        .dir  (ctl.dir),
        .dec  (ctl.dec),
        .en_a (en_a),
        .en_b (en_b),
        .tc   (tc),
        .rco  (rco)
    );

    assign cnt_q = cnt_r;
endmodule

// File: rtl/updn_stage_chk.sv
module updn_stage_chk #(
    parameter int W       = 4,
    parameter int DEC_MAX = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         load_en,
    input logic [W-1:0] load_val,
    input logic         dir_down,
    input logic         en_a,
    input logic         en_b,
    input logic         decade_sel,
    input logic [W-1:0] cnt_q,
    input logic         tc,
    input logic         rco
);
    logic [W-1:0] lim;
    assign lim = decade_sel ? W'(DEC_MAX) : {W{1'b1}};

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q == 1'b1) begin
            assert_sync_clear_R1: assert (cnt_q == '0)
                else $error("R1: count %0d after reset", cnt_q);
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cnt_q == $past(load_val));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !(en_a && en_b)) |=> $stable(cnt_q));

    assert_up_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_en && en_a && en_b && !dir_down && !tc && cnt_q < lim)
        |=> cnt_q == $past(cnt_q) + W'(1));

    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (rco && !load_en && !dir_down) |=> cnt_q == '0);

    assert_down_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (rco && !load_en && dir_down) |=> cnt_q == $past(lim));

    assert_carry_moves_R7: assert property (@(posedge clk) disable iff (rst)
        (rco && !load_en) |=> cnt_q != $past(cnt_q));

    assert_dec_recover_R8: assert property (@(posedge clk) disable iff (rst)
        (decade_sel && !load_en && en_a && en_b && cnt_q > W'(DEC_MAX))
        |=> cnt_q == (dir_down ? W'(DEC_MAX) : '0) || $past(dir_down) != dir_down
            || cnt_q == ($past(dir_down) ? W'(DEC_MAX) : '0));
endmodule

bind updn_stage updn_stage_chk #(.W(W), .DEC_MAX(DEC_MAX)) u_chk (.*);

// File: tb/tb_updn_stage.sv
module tb_updn_stage;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld = 1'b0;
    logic [3:0] lv = 4'd0;
    logic       dn = 1'b0;
    logic       ea = 1'b0;
    logic       eb = 1'b0;
    logic       dec = 1'b0;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo, rco_lo, tc_hi, rco_hi;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    updn_stage dut (
        .clk(clk), .rst(rst), .load_en(ld), .load_val(lv), .dir_down(dn),
        .en_a(ea), .en_b(eb), .decade_sel(dec),
        .cnt_q(q_lo), .tc(tc_lo), .rco(rco_lo)
    );

    // Upper digit: cascade via en_b, always enabled on en_a
    updn_stage dut_hi (
        .clk(clk), .rst(rst), .load_en(ld), .load_val(lv), .dir_down(dn),
        .en_a(1'b1), .en_b(rco_lo), .decade_sel(dec),
        .cnt_q(q_hi), .tc(tc_hi), .rco(rco_hi)
    );

    typedef struct {
        logic [3:0] lo;
        logic [3:0] hi;
        string      req;
    } item_t;

    item_t sb[$];
    logic [3:0] m_lo = 4'd0;
    logic [3:0] m_hi = 4'd0;

    function automatic logic [3:0] lim_of(input logic d);
        return d ? 4'd9 : 4'd15;
    endfunction

    function automatic logic m_tc(input logic [3:0] q, input logic d, input logic dcm);
        return d ? (q == 4'd0) : (q == lim_of(dcm));
    endfunction

    function automatic logic [3:0] m_next(input logic [3:0] q, input logic step,
                                          input logic d, input logic dcm);
        logic [3:0] l;
        l = lim_of(dcm);
        if (rst)   return 4'd0;
        if (ld)    return lv;
        if (!step) return q;
        if (!d)    return (q >= l) ? 4'd0 : q + 4'd1;
        if (q == 4'd0 || q > l) return l;
        return q - 4'd1;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check combinational flags, queue next counts
    task automatic step(input string req, input logic r, input logic l, input logic [3:0] v,
                        input logic d, input logic a, input logic b, input logic dcm);
        logic e_tc, e_rco;
        item_t it;
        rst = r; ld = l; lv = v; dn = d; ea = a; eb = b; dec = dcm;
        #1;
        e_tc  = m_tc(m_lo, d, dcm);
        e_rco = e_tc && a && b;
        check({req, " tc (R6)"},  {3'b0, tc_lo},  {3'b0, e_tc});
        check({req, " rco (R7)"}, {3'b0, rco_lo}, {3'b0, e_rco});
        it.lo  = m_next(m_lo, a && b, d, dcm);
        it.hi  = m_next(m_hi, e_rco, d, dcm);
        it.req = req;
        m_lo = it.lo;
        m_hi = it.hi;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compare registered counts one edge after each stimulus
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check({it.req, " low digit"},  q_lo, it.lo);
                check({it.req, " high digit"}, q_hi, it.hi);
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state and reset over load
        step("R1 reset", 1, 1, 4'd7, 0, 1, 1, 0);
        // R4: binary up through the 15 -> 0 wrap
        for (int i = 0; i < 18; i++) step("R4 bin up", 0, 0, 4'd0, 0, 1, 1, 0);
        // R3: each enable alone low holds
        step("R3 en_a low", 0, 0, 4'd0, 0, 0, 1, 0);
        step("R3 en_b low", 0, 0, 4'd0, 0, 1, 0, 0);
        step("R3 both low", 0, 0, 4'd0, 1, 0, 0, 0);
        // R2: load, and load over counting
        step("R2 load", 0, 1, 4'd15, 0, 0, 0, 0);
        step("R7 tc no enable", 0, 0, 4'd0, 0, 1, 0, 0);
        step("R2 load over count", 0, 1, 4'd2, 0, 1, 1, 0);
        // R5: binary down through 0 -> 15
        for (int i = 0; i < 5; i++) step("R5 bin down", 0, 0, 4'd0, 1, 1, 1, 0);
        // R5 / R4: decade wraps
        step("R2 load 0", 0, 1, 4'd0, 0, 0, 0, 1);
        step("R5 dec down", 0, 0, 4'd0, 1, 1, 1, 1);
        step("R4 dec up", 0, 0, 4'd0, 0, 1, 1, 1);
        step("R4 dec up", 0, 0, 4'd0, 0, 1, 1, 1);
        // R8: out-of-range decade values
        step("R8 load 12", 0, 1, 4'd12, 0, 0, 0, 1);
        step("R8 up", 0, 0, 4'd0, 0, 1, 1, 1);
        step("R8 load 13", 0, 1, 4'd13, 1, 0, 0, 1);
        step("R8 down", 0, 0, 4'd0, 1, 1, 1, 1);
        // R9: two-digit decimal chain
        step("R9 clear", 1, 0, 4'd0, 0, 0, 0, 1);
        for (int i = 0; i < 25; i++) step("R9 chain up", 0, 0, 4'd0, 0, 1, 1, 1);
        for (int i = 0; i < 8; i++)  step("R9 chain down", 0, 0, 4'd0, 1, 1, 1, 1);
        step("R1 final reset", 1, 0, 4'd0, 1, 1, 1, 1);
        step("R3 idle", 0, 0, 4'd0, 0, 0, 0, 0);
        @(posedge clk);
        #3;
        n_chk++;
        if (q_hi * 10 + q_lo != 0) begin
            n_bad++;
            $display("FAIL R9: actual %0d expected 0", q_hi * 10 + q_lo);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule